// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block is a circular buffer that holds instruction results from the moment they finish executing until they retire in program order. The front end reserves an entry at the tail for each instruction it dispatches and receives the entry index as a rename tag. That tag is what later consumers wait on. Execution units report a finished result against its tag, together with an exception flag or a misprediction flag. The oldest entry retires once it is ready. Only at that point does the block drive a register-file write, release a store, raise an exception or redirect fetch. A consumer with a pending operand reads the value from the buffer by tag, not from the unit that produced it.

Speculation is undone in two ways. When a mispredicted branch retires, or when a faulting entry retires, every younger entry is discarded in that same cycle. An external squash input also empties the buffer completely. The buffer depth must be a power of two. An extra wrap bit on each pointer tells a full buffer apart from an empty one.

Top module: `spec_rob`

## Requirements
- R1: An allocation is accepted (`alloc_ok` high) only while fewer than DEPTH entries are live. `alloc_tag` is the tail index, and successive accepted allocations receive consecutive tags modulo DEPTH. With DEPTH entries live, `alloc_ok` is low.
- R2: `alloc_kind` is encoded as follows: 0 means register-writing, 1 means store, 2 means branch. The kind and `alloc_dest` are recorded in the entry and decide what its retirement drives.
- R3: Entries retire strictly from the head in allocation order. A younger entry that is ready waits until every older entry has retired.
- R4: A register-writing entry drives `rf_we` with its destination and value in the cycle after its completion is captured, and only while it is at the head. A completion never writes the register file by itself.
- R5: A store entry pulses `st_release` with `st_tag` equal to its index when it retires, and `rf_we` stays low.
- R6: From the cycle after a completion is captured, a lookup of that tag returns `peek_ready` high with the completed value. Before that, the lookup returns `peek_ready` low.
- R7: An exception flag recorded at completion has no visible effect until its entry is ready at the head. In that cycle `exc_out` is high with `exc_tag`, there is no register write, allocation is refused, and the buffer is empty in the next cycle, with the next tag equal to the faulting index plus one.
- R8: A branch completed with the mispredict flag retires with `redirect` high and `redirect_pc` equal to its completion value, and all younger entries are discarded. A correctly predicted branch retires with no output, and the entries younger than it survive.
- R9: `squash` empties the buffer at the next edge, leaving the next tag equal to the current head index. In the squash cycle no retirement output is driven and allocation is refused.
- R10: A lookup of a tag that names no live entry reports `peek_ready` low.
- R11: One allocation, one completion and one retirement can all take effect in the same cycle.
- R12: After reset the buffer is empty, `alloc_ok` is high, `alloc_tag` is 0 and no retirement output is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Request to reserve a tail entry |
| alloc_kind | input | 2 | Instruction kind: 0 register, 1 store, 2 branch |
| alloc_dest | input | REG_W | Destination register number |
| alloc_ok | output | 1 | Allocation accepted this cycle |
| alloc_tag | output | IDX_W | Tag given to the allocated entry |
| done_valid | input | 1 | Completion write strobe |
| done_tag | input | IDX_W | Entry being completed |
| done_value | input | DATA_W | Result value, or the corrected PC for a branch |
| done_exc | input | 1 | Completion carries an exception |
| done_mispred | input | 1 | Branch was mispredicted |
| peek_tag | input | IDX_W | Operand lookup tag |
| peek_ready | output | 1 | Looked-up entry is live and complete |
| peek_value | output | DATA_W | Value of the looked-up entry |
| squash | input | 1 | Discard every entry |
| rf_we | output | 1 | Register-file write at retirement |
| rf_waddr | output | REG_W | Register-file write address |
| rf_wdata | output | DATA_W | Register-file write data |
| st_release | output | 1 | Store may now update memory |
| st_tag | output | IDX_W | Tag of the released store |
| redirect | output | 1 | Mispredicted branch retired |
| redirect_pc | output | DATA_W | Corrected fetch address |
| exc_out | output | 1 | Faulting entry retired |
| exc_tag | output | IDX_W | Tag of the faulting entry |

## Verification
A wrong head or tail pointer shows up at the ports within one cycle. The next `alloc_tag` after a flush or a squash would be off, or a retirement would drive the wrong destination in the very cycle the head entry becomes ready. A valid or ready bit that is stale or never cleared shows up either as an extra register write from a discarded entry in the cycle after a flush, or as a missing write in the cycle after completion. The directed scenarios therefore check the retirement outputs cycle by cycle and compare the next tag after each kind of flush.

// File: rtl/spec_rob.sv
module spec_rob #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_req,
  input  logic [1:0]        alloc_kind,
  input  logic [REG_W-1:0]  alloc_dest,
  output logic              alloc_ok,
  output logic [IDX_W-1:0]  alloc_tag,
  input  logic              done_valid,
  input  logic [IDX_W-1:0]  done_tag,
  input  logic [DATA_W-1:0] done_value,
  input  logic              done_exc,
  input  logic              done_mispred,
  input  logic [IDX_W-1:0]  peek_tag,
  output logic              peek_ready,
  output logic [DATA_W-1:0] peek_value,
  input  logic              squash,
  output logic              rf_we,
  output logic [REG_W-1:0]  rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              st_release,
  output logic [IDX_W-1:0]  st_tag,
  output logic              redirect,
  output logic [DATA_W-1:0] redirect_pc,
  output logic              exc_out,
  output logic [IDX_W-1:0]  exc_tag
);
  localparam logic [1:0] KIND_REG = 2'd0;
  localparam logic [1:0] KIND_ST  = 2'd1;
  localparam logic [1:0] KIND_BR  = 2'd2;

  logic [PTR_W-1:0]  head_q, tail_q;
  logic [DEPTH-1:0]  vld_q, rdy_q, exc_q, mis_q;
  logic [1:0]        kind_q [DEPTH];
  logic [REG_W-1:0]  dst_q  [DEPTH];
  logic [DATA_W-1:0] val_q  [DEPTH];

  wire [IDX_W-1:0] hidx  = head_q[IDX_W-1:0];
  wire [IDX_W-1:0] tidx  = tail_q[IDX_W-1:0];
  wire [PTR_W-1:0] used  = tail_q - head_q;
  wire             full  = (used == PTR_W'(DEPTH));
  wire             empty = (head_q == tail_q);

  wire head_go  = vld_q[hidx] & rdy_q[hidx] & ~squash;
  wire head_exc = exc_q[hidx];
  wire kill_exc = head_go & head_exc;
  wire kill_br  = head_go & ~head_exc & mis_q[hidx] & (kind_q[hidx] == KIND_BR);
  wire kill     = squash | kill_exc | kill_br;
  wire take     = alloc_req & alloc_ok;
  wire done_hit = done_valid & vld_q[done_tag];

  assign alloc_ok    = ~full & ~kill;
  assign alloc_tag   = tidx;
  assign peek_ready  = vld_q[peek_tag] & rdy_q[peek_tag];
  assign peek_value  = val_q[peek_tag];
  assign rf_we       = head_go & ~head_exc & (kind_q[hidx] == KIND_REG);
  assign rf_waddr    = dst_q[hidx];
  assign rf_wdata    = val_q[hidx];
  assign st_release  = head_go & ~head_exc & (kind_q[hidx] == KIND_ST);
  assign st_tag      = hidx;
  assign redirect    = kill_br;
  assign redirect_pc = val_q[hidx];
  assign exc_out     = kill_exc;
  assign exc_tag     = hidx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      vld_q  <= '0;
    end else if (kill) begin
      vld_q <= '0;
      if (head_go) begin
        head_q <= head_q + PTR_W'(1);
        tail_q <= head_q + PTR_W'(1);
      end else begin
        tail_q <= head_q;
      end
    end else begin
      if (take) begin
        vld_q[tidx] <= 1'b1;
        tail_q      <= tail_q + PTR_W'(1);
      end
      if (head_go) begin
        vld_q[hidx] <= 1'b0;
        head_q      <= head_q + PTR_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      kind_q[tidx] <= alloc_kind;
      dst_q[tidx]  <= alloc_dest;
      rdy_q[tidx]  <= 1'b0;
      exc_q[tidx]  <= 1'b0;
      mis_q[tidx]  <= 1'b0;
    end
    if (done_hit) begin
      val_q[done_tag] <= done_value;
      rdy_q[done_tag] <= 1'b1;
      exc_q[done_tag] <= done_exc;
      mis_q[done_tag] <= done_mispred;
    end
  end

  assert_occupancy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    used <= PTR_W'(DEPTH));

  assert_alloc_live_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && alloc_ok) |=> vld_q[$past(alloc_tag)]);

  assert_single_action_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rf_we, st_release, redirect, exc_out}));

  assert_exc_drains_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_out |=> empty);

  assert_redirect_drains_R8: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> empty);

  assert_squash_drains_R9: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> (empty && vld_q == '0));
endmodule

// File: tb/sim_spec_rob.sv
module sim_spec_rob;
  localparam int DEPTH = 8;
  localparam int DW = 32;
  localparam int RW = 5;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic alloc_req, done_valid, done_exc, done_mispred, squash;
  logic [1:0] alloc_kind;
  logic [RW-1:0] alloc_dest;
  logic [IW-1:0] done_tag, peek_tag;
  logic [DW-1:0] done_value;
  logic alloc_ok, peek_ready, rf_we, st_release, redirect, exc_out;
  logic [IW-1:0] alloc_tag, st_tag, exc_tag;
  logic [DW-1:0] peek_value, rf_wdata, redirect_pc;
  logic [RW-1:0] rf_waddr;

  int vecs = 0;
  int bad = 0;
  logic [IW-1:0] eh, et;

  always #5 clk = ~clk;

  spec_rob #(.DEPTH(DEPTH), .DATA_W(DW), .REG_W(RW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .alloc_req(alloc_req), .alloc_kind(alloc_kind), .alloc_dest(alloc_dest),
    .alloc_ok(alloc_ok), .alloc_tag(alloc_tag),
    .done_valid(done_valid), .done_tag(done_tag), .done_value(done_value),
    .done_exc(done_exc), .done_mispred(done_mispred),
    .peek_tag(peek_tag), .peek_ready(peek_ready), .peek_value(peek_value),
    .squash(squash),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .st_release(st_release), .st_tag(st_tag),
    .redirect(redirect), .redirect_pc(redirect_pc),
    .exc_out(exc_out), .exc_tag(exc_tag)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_alloc(input logic [1:0] k, input logic [RW-1:0] d, output logic [IW-1:0] tag);
    alloc_req = 1'b1; alloc_kind = k; alloc_dest = d;
    #1;
    chk("R1", "alloc_ok", alloc_ok, 1);
    chk("R1", "alloc_tag", alloc_tag, et);
    tag = et;
    tick();
    alloc_req = 1'b0;
    et = et + 1'b1;
  endtask

  task automatic do_done(input logic [IW-1:0] tag, input logic [DW-1:0] v, input logic e, input logic m);
    done_valid = 1'b1; done_tag = tag; done_value = v; done_exc = e; done_mispred = m;
    tick();
    done_valid = 1'b0; done_exc = 1'b0; done_mispred = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    #1;
    chk("R12", "alloc_ok", alloc_ok, 1);
    chk("R12", "alloc_tag", alloc_tag, 0);
    chk("R12", "rf_we", rf_we, 0);
    chk("R12", "redirect", redirect, 0);
    chk("R12", "exc_out", exc_out, 0);
  endtask

  task automatic t_basic();
    logic [IW-1:0] t;
    do_alloc(2'd0, 5'd5, t);
    peek_tag = t;
    #1;
    chk("R6", "peek_ready before completion", peek_ready, 0);
    done_valid = 1'b1; done_tag = t; done_value = 32'hAA; done_exc = 0; done_mispred = 0;
    #1;
    chk("R4", "rf_we during completion", rf_we, 0);
    tick();
    done_valid = 1'b0;
    #1;
    chk("R6", "peek_ready", peek_ready, 1);
    chk("R6", "peek_value", peek_value, 32'hAA);
    chk("R4", "rf_we", rf_we, 1);
    chk("R2", "rf_waddr", rf_waddr, 5);
    chk("R4", "rf_wdata", rf_wdata, 32'hAA);
    tick(); eh = eh + 1'b1;
    chk("R4", "rf_we after retire", rf_we, 0);
  endtask

  task automatic t_order();
    logic [IW-1:0] a, b, c;
    do_alloc(2'd0, 5'd1, a);
    do_alloc(2'd0, 5'd2, b);
    do_alloc(2'd0, 5'd3, c);
    do_done(c, 32'h33, 0, 0);
    chk("R3", "young ready waits", rf_we, 0);
    do_done(b, 32'h22, 0, 0);
    chk("R3", "middle ready waits", rf_we, 0);
    do_done(a, 32'h11, 0, 0);
    chk("R3", "first rf_we", rf_we, 1);
    chk("R3", "first addr", rf_waddr, 1);
    chk("R3", "first data", rf_wdata, 32'h11);
    tick();
    chk("R3", "second addr", rf_waddr, 2);
    chk("R3", "second data", rf_wdata, 32'h22);
    tick();
    chk("R3", "third addr", rf_waddr, 3);
    chk("R3", "third we", rf_we, 1);
    tick();
    chk("R3", "drained", rf_we, 0);
    eh = eh + 3'd3;
  endtask

  task automatic t_store();
    logic [IW-1:0] s;
    do_alloc(2'd1, 5'd0, s);
    do_done(s, 32'h55, 0, 0);
    chk("R5", "st_release", st_release, 1);
    chk("R5", "st_tag", st_tag, s);
    chk("R5", "rf_we on store", rf_we, 0);
    tick(); eh = eh + 1'b1;
    chk("R5", "st_release drops", st_release, 0);
  endtask

  task automatic t_concurrent();
    logic [IW-1:0] p, q, r;
    do_alloc(2'd0, 5'd10, p);
    do_alloc(2'd0, 5'd11, q);
    do_done(p, 32'h100, 0, 0);
    alloc_req = 1'b1; alloc_kind = 2'd0; alloc_dest = 5'd12;
    done_valid = 1'b1; done_tag = q; done_value = 32'h200;
    #1;
    chk("R11", "retire p", rf_we, 1);
    chk("R11", "retire p addr", rf_waddr, 10);
    chk("R11", "alloc_ok", alloc_ok, 1);
    chk("R11", "alloc_tag", alloc_tag, et);
    r = et;
    tick();
    alloc_req = 1'b0; done_valid = 1'b0;
    et = et + 1'b1; eh = eh + 1'b1;
    #1;
    chk("R11", "retire q addr", rf_waddr, 11);
    chk("R11", "retire q data", rf_wdata, 32'h200);
    chk("R11", "retire q we", rf_we, 1);
    tick(); eh = eh + 1'b1;
    do_done(r, 32'h300, 0, 0);
    chk("R11", "retire r addr", rf_waddr, 12);
    tick(); eh = eh + 1'b1;
  endtask

  task automatic t_full_squash();
    logic [IW-1:0] t;
    for (int i = 0; i < DEPTH; i++) do_alloc(2'd0, RW'(i + 1), t);
    alloc_req = 1'b1;
    #1;
    chk("R1", "alloc_ok when full", alloc_ok, 0);
    alloc_req = 1'b0;
    do_done(eh, 32'h77, 0, 0);
    squash = 1'b1;
    #1;
    chk("R9", "rf_we during squash", rf_we, 0);
    chk("R9", "alloc_ok during squash", alloc_ok, 0);
    tick();
    squash = 1'b0;
    et = eh;
    #1;
    chk("R9", "tag after squash", alloc_tag, eh);
    chk("R9", "alloc_ok after squash", alloc_ok, 1);
    peek_tag = eh;
    #1;
    chk("R10", "peek dead head", peek_ready, 0);
    peek_tag = eh + 3'd3;
    #1;
    chk("R10", "peek dead entry", peek_ready, 0);
    tick();
    chk("R9", "no retire after squash", rf_we, 0);
  endtask

  task automatic t_exception();
    logic [IW-1:0] a, b, c, n;
    do_alloc(2'd0, 5'd7, a);
    do_alloc(2'd0, 5'd8, b);
    do_alloc(2'd0, 5'd9, c);
    do_done(b, 32'hBB, 1, 0);
    chk("R7", "exc held while not head", exc_out, 0);
    do_done(a, 32'hAA, 0, 0);
    chk("R7", "older retires first", rf_we, 1);
    chk("R7", "older addr", rf_waddr, 7);
    chk("R7", "exc not yet", exc_out, 0);
    tick(); eh = eh + 1'b1;
    chk("R7", "exc_out", exc_out, 1);
    chk("R7", "exc_tag", exc_tag, b);
    chk("R7", "no rf write on fault", rf_we, 0);
    chk("R7", "alloc refused", alloc_ok, 0);
    tick();
    eh = b + 1'b1; et = b + 1'b1;
    chk("R7", "exc_out drops", exc_out, 0);
    chk("R7", "tag after fault", alloc_tag, et);
    do_done(c, 32'hCC, 0, 0);
    chk("R7", "discarded entry silent", rf_we, 0);
    do_alloc(2'd0, 5'd1, n);
    #1;
    chk("R7", "fresh entry not retiring", rf_we, 0);
    do_done(n, 32'h9, 0, 0);
    chk("R7", "fresh entry retires", rf_waddr, 1);
    tick(); eh = eh + 1'b1;
  endtask

  task automatic t_branch();
    logic [IW-1:0] br, x, br2, y;
    do_alloc(2'd2, 5'd0, br);
    do_alloc(2'd0, 5'd4, x);
    do_done(x, 32'h44, 0, 0);
    chk("R8", "no action before branch", rf_we, 0);
    do_done(br, 32'h1234, 0, 1);
    chk("R8", "redirect", redirect, 1);
    chk("R8", "redirect_pc", redirect_pc, 32'h1234);
    chk("R8", "rf_we at redirect", rf_we, 0);
    chk("R8", "alloc refused", alloc_ok, 0);
    tick();
    eh = br + 1'b1; et = br + 1'b1;
    chk("R8", "redirect drops", redirect, 0);
    chk("R8", "younger discarded", rf_we, 0);
    chk("R8", "tag after redirect", alloc_tag, et);
    do_alloc(2'd2, 5'd0, br2);
    do_alloc(2'd0, 5'd6, y);
    do_done(y, 32'h66, 0, 0);
    do_done(br2, 32'h50, 0, 0);
    chk("R8", "good branch no redirect", redirect, 0);
    chk("R8", "good branch no write", rf_we, 0);
    chk("R5", "good branch no release", st_release, 0);
    tick(); eh = eh + 1'b1;
    chk("R8", "survivor retires", rf_we, 1);
    chk("R8", "survivor addr", rf_waddr, 6);
    tick(); eh = eh + 1'b1;
    chk("R8", "tag kept", alloc_tag, et);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; alloc_req = 0; alloc_kind = 0; alloc_dest = 0;
    done_valid = 0; done_tag = 0; done_value = 0; done_exc = 0; done_mispred = 0;
    peek_tag = 0; squash = 0; eh = 0; et = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_basic();
    t_order();
    t_store();
    t_concurrent();
    t_full_squash();
    t_exception();
    t_branch();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule